// File: doc/BRIEF.md
# Multi-Cycle 16-bit Processor Core

This block is a small load/store processor with a 16-bit data path that takes instructions and data from one shared memory port. A Moore-style control sequencer moves each instruction through a fetch cycle and a decode cycle, then through one or more execute cycles. The datapath holds a program counter, an instruction register, eight general registers, two operand latches and a memory address latch. It has a single ALU, which also increments the program counter, forms memory addresses and computes branch targets.

The core sits on a memory whose read data is valid combinationally in the cycle the address is driven. A write takes effect at the clock edge that ends a cycle with the write strobe high. The core runs from address zero after reset until it executes a halt. It then raises its halted output and stays quiet until the next reset.

Instruction fields, high bit first: op[15:13] and rs[12:10] in every non-jump format. The register format continues with rt[9:7], rd[6:4] and fn[3:0]. The immediate format continues with rt[9:7] and off[6:0]. The jump format is op[15:13] followed by tgt[12:0].

Top module: `mc16_core`

## Requirements
- R1: While reset (active low, synchronous) is held, and in the first cycle after it is released, the core fetches from address 0 with the read strobe high, and halted is low.
- R2: Every instruction starts with one fetch cycle. That cycle drives the PC on the address bus with the read strobe high, loads the instruction register and leaves PC+1 in the PC. A decode cycle then latches rs and rt.
- R3: Opcode 0 with fn 0, 1, 2 or 3 writes rs+rt, rs−rt, rs AND rt or rs OR rt into rd, and takes 3 cycles.
- R4: Opcode 0 with fn 4 writes 1 into rd when rs is less than rt as signed two's-complement numbers, and 0 otherwise.
- R5: Opcode 4 (addi) writes rs plus the sign-extended 7-bit offset into rt, and takes 3 cycles.
- R6: Opcode 1 (lw) loads rt from memory at rs plus the sign-extended offset, using a separate address cycle and a write-back read cycle: 4 cycles in total.
- R7: Opcode 2 (sw) writes rt to memory at rs plus the sign-extended offset, with exactly one write-strobe cycle; it takes 3 cycles.
- R8: Opcode 3 (beq) compares rs and rt through the zero flag of rs−rt. When they are equal, the PC becomes PC+1 plus the sign-extended offset and the instruction takes 4 cycles. Otherwise it falls through in 3 cycles.
- R9: Opcode 5 (j) loads the PC with the zero-extended 13-bit target, and takes 3 cycles.
- R10: Opcode 7 (halt) leaves the core in a state where halted is high, no strobe is asserted and no state changes, until reset.
- R11: Opcode 6, or opcode 0 with fn 5 to 15, changes no register and no memory word, and returns to fetch after decode.
- R12: Register r0 is an ordinary register: it can be written, and it then serves as a base with its new value.
- R13: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Word address for fetch and data access |
| mem_wdata | output | 16 | Store data (value of rt) |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High while the core is stopped by a halt |

## Verification
The bench aims at values that tell apart a wrong sign treatment. Three examples: a negative immediate, a signed less-than that an unsigned compare would answer the other way, and a load with a negative offset that reads back an instruction word. Branches are run both taken and not taken, and forward and backward. One loop counts its iterations, so an off-by-one branch base or a fall-through taken by mistake shows up as a wrong stored count. Undefined opcodes and fn codes sit just before a store of the register they name, so a design that executed them would store a changed value. A cycle count from reset to halt, over a mix of instruction types, exposes any class that takes one cycle too many or too few. The halted state is then watched for stray strobes, and a reset from halt must restart the program cleanly.

// File: rtl/mc16_pkg.sv
// mc16_pkg: shared widths, opcodes, controller states and the control word
// of the multi-cycle core. Assumes the fixed 16-bit, three-format encoding.
package mc16_pkg;
    localparam int XLEN   = 16;
    localparam int REG_N  = 8;
    localparam int REG_AW = $clog2(REG_N);
    localparam int OP_W   = 3;
    localparam int FN_W   = 4;
    localparam int OFF_W  = 7;
    localparam int TGT_W  = 13;

    localparam logic [OP_W-1:0] OPC_REG  = 3'd0;
    localparam logic [OP_W-1:0] OPC_LOAD = 3'd1;
    localparam logic [OP_W-1:0] OPC_STOR = 3'd2;
    localparam logic [OP_W-1:0] OPC_BEQ  = 3'd3;
    localparam logic [OP_W-1:0] OPC_ADDI = 3'd4;
    localparam logic [OP_W-1:0] OPC_JMP  = 3'd5;
    localparam logic [OP_W-1:0] OPC_STOP = 3'd7;
    localparam logic [FN_W-1:0] FN_LAST  = 4'd4;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_EXE_REG, ST_EXE_ADDI, ST_LD_ADDR,
        ST_LD_WB, ST_STORE, ST_BR_CMP, ST_BR_TAKE, ST_JUMP, ST_STOP
    } state_e;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
    typedef enum logic       {ASEL_PC, ASEL_A} asel_e;
    typedef enum logic [1:0] {BSEL_B, BSEL_ONE, BSEL_OFF} bsel_e;
    typedef enum logic [1:0] {MA_PC, MA_ALU, MA_LATCH} masel_e;

    typedef struct packed {
        alu_op_e op;
        asel_e   asel;
        bsel_e   bsel;
        masel_e  masel;
        logic    pc_ld_alu;
        logic    pc_ld_tgt;
        logic    ir_ld;
        logic    ab_ld;
        logic    addr_ld;
        logic    rf_we;
        logic    dst_rd;
        logic    wb_mem;
        logic    mem_rd;
        logic    mem_wr;
        logic    stopped;
    } ctrl_t;
endpackage

// File: rtl/mc16_alu.sv
// mc16_alu: the single shared ALU. Add, subtract, and, or and signed
// set-less-than, plus a zero flag. Purely combinational.
module mc16_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  mc16_pkg::alu_op_e op,
    output logic [W-1:0]     y,
    output logic             zero
);
    import mc16_pkg::*;

    // Operation select.
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/mc16_regfile.sv
// mc16_regfile: N general registers with two combinational read ports and one
// synchronous write port. All registers clear on reset; r0 is writable.
module mc16_regfile #(
    parameter int W = 16,
    parameter int N = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // Storage for register g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == AW'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mc16_ctrl.sv
// mc16_ctrl: Moore control sequencer. Fetch, decode, then an execute
// sequence chosen from op and fn. Outputs depend only on the state; only the
// next-state choice after a branch compare looks at the ALU zero flag.
module mc16_ctrl
    import mc16_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op,
    input  logic [FN_W-1:0] fn,
    input  logic            alu_zero,
    output ctrl_t           ctl
);
    state_e state_q, state_d;

    // State register; reset returns to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Next-state selection.
    always_comb begin
        state_d = ST_FETCH;
        case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                case (op)
                    OPC_REG:  state_d = (fn <= FN_LAST) ? ST_EXE_REG : ST_FETCH;
                    OPC_LOAD: state_d = ST_LD_ADDR;
                    OPC_STOR: state_d = ST_STORE;
                    OPC_BEQ:  state_d = ST_BR_CMP;
                    OPC_ADDI: state_d = ST_EXE_ADDI;
                    OPC_JMP:  state_d = ST_JUMP;
                    OPC_STOP: state_d = ST_STOP;
                    default:  state_d = ST_FETCH;
                endcase
            end
            ST_LD_ADDR: state_d = ST_LD_WB;
            ST_BR_CMP:  state_d = alu_zero ? ST_BR_TAKE : ST_FETCH;
            ST_STOP:    state_d = ST_STOP;
            default:    state_d = ST_FETCH;
        endcase
    end

    // Control word per state.
    always_comb begin
        ctl = '0;
        ctl.op    = ALU_ADD;
        ctl.asel  = ASEL_A;
        ctl.bsel  = BSEL_OFF;
        ctl.masel = MA_PC;
        case (state_q)
            ST_FETCH: begin
                ctl.asel = ASEL_PC;  ctl.bsel = BSEL_ONE;
                ctl.mem_rd = 1'b1;   ctl.ir_ld = 1'b1;  ctl.pc_ld_alu = 1'b1;
            end
            ST_DECODE: ctl.ab_ld = 1'b1;
            ST_EXE_REG: begin
                ctl.bsel = BSEL_B;  ctl.rf_we = 1'b1;  ctl.dst_rd = 1'b1;
                case (fn)
                    4'd0:    ctl.op = ALU_ADD;
                    4'd1:    ctl.op = ALU_SUB;
                    4'd2:    ctl.op = ALU_AND;
                    4'd3:    ctl.op = ALU_OR;
                    default: ctl.op = ALU_SLT;
                endcase
            end
            ST_EXE_ADDI: ctl.rf_we = 1'b1;
            ST_LD_ADDR:  ctl.addr_ld = 1'b1;
            ST_LD_WB: begin
                ctl.masel = MA_LATCH; ctl.mem_rd = 1'b1;
                ctl.rf_we = 1'b1;     ctl.wb_mem = 1'b1;
            end
            ST_STORE: begin
                ctl.masel = MA_ALU;  ctl.mem_wr = 1'b1;
            end
            ST_BR_CMP: begin
                ctl.op = ALU_SUB;  ctl.bsel = BSEL_B;
            end
            ST_BR_TAKE: begin
                ctl.asel = ASEL_PC;  ctl.pc_ld_alu = 1'b1;
            end
            ST_JUMP: ctl.pc_ld_tgt = 1'b1;
            ST_STOP: ctl.stopped = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mc16_core.sv
// mc16_core: top of the multi-cycle core. Holds PC, instruction register,
// operand latches and the load address latch, and steers the shared ALU and
// the single memory port. Assumes read data is valid combinationally.
module mc16_core (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        halted
);
    import mc16_pkg::*;

    ctrl_t             ctl;
    logic [XLEN-1:0]   pc_q, ir_q, a_q, b_q, addr_q;
    logic [XLEN-1:0]   rf_a, rf_b, alu_a, alu_b, alu_y, wb_data;
    logic [XLEN-1:0]   off_sx, tgt_zx;
    logic              alu_zero;
    logic [REG_AW-1:0] f_rs, f_rt, f_rd, wb_reg;

    assign f_rs   = ir_q[12:10];
    assign f_rt   = ir_q[9:7];
    assign f_rd   = ir_q[6:4];
    assign off_sx = {{(XLEN-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};
    assign tgt_zx = {{(XLEN-TGT_W){1'b0}}, ir_q[TGT_W-1:0]};

    mc16_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (ir_q[15:13]),
        .fn       (ir_q[3:0]),
        .alu_zero (alu_zero),
        .ctl      (ctl)
    );

    // ALU operand steering.
    always_comb begin
        alu_a = (ctl.asel == ASEL_PC) ? pc_q : a_q;
        case (ctl.bsel)
            BSEL_B:   alu_b = b_q;
            BSEL_ONE: alu_b = {{(XLEN-1){1'b0}}, 1'b1};
            default:  alu_b = off_sx;
        endcase
    end

    mc16_alu #(.W(XLEN)) alu_i (
        .a    (alu_a),
        .b    (alu_b),
        .op   (ctl.op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wb_reg  = ctl.dst_rd ? f_rd : f_rt;
    assign wb_data = ctl.wb_mem ? mem_rdata : alu_y;

    mc16_regfile #(.W(XLEN), .N(REG_N)) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl.rf_we),
        .waddr   (wb_reg),
        .wdata   (wb_data),
        .raddr_a (f_rs),
        .raddr_b (f_rt),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    // Program counter: ALU result on fetch/branch, target on jump.
    always_ff @(posedge clk) begin
        if (!rst_n)            pc_q <= '0;
        else if (ctl.pc_ld_alu) pc_q <= alu_y;
        else if (ctl.pc_ld_tgt) pc_q <= tgt_zx;
    end

    // Instruction, operand and address latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0; a_q <= '0; b_q <= '0; addr_q <= '0;
        end else begin
            if (ctl.ir_ld)   ir_q   <= mem_rdata;
            if (ctl.ab_ld)   begin a_q <= rf_a; b_q <= rf_b; end
            if (ctl.addr_ld) addr_q <= alu_y;
        end
    end

    // Memory address source.
    always_comb begin
        case (ctl.masel)
            MA_ALU:   mem_addr = alu_y;
            MA_LATCH: mem_addr = addr_q;
            default:  mem_addr = pc_q;
        endcase
    end

    assign mem_wdata = b_q;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign halted    = ctl.stopped;
endmodule

// File: rtl/mc16_core_chk.sv
// mc16_core_chk: protocol and sequencing properties of mc16_core, attached
// with bind. Observes ports plus the PC, fetch enable and register write.
module mc16_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] mem_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        halted,
    input logic [15:0] pc,
    input logic        in_fetch,
    input logic        rf_we
);
    logic was_rst_q;

    // Remembers that the previous edge saw reset asserted.
    always_ff @(posedge clk) was_rst_q <= !rst_n;

    AST_RESET_START: assert property (@(posedge clk)
        (was_rst_q && rst_n) |-> (mem_rd && mem_addr == 16'd0 && !halted)); // R1

    AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        in_fetch |-> (mem_rd && mem_addr == pc)); // R2

    AST_FETCH_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_fetch) |=> (pc == $past(pc) + 16'd1)); // R2

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R13

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc))); // R10

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr && !rf_we)); // R10
endmodule

bind mc16_core mc16_core_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .halted   (halted),
    .pc       (pc_q),
    .in_fetch (ctl.ir_ld),
    .rf_we    (ctl.rf_we)
);

// File: tb/mc16_core_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: programs are loaded into a behavioural memory, expected
// stores are queued by the driver, and a monitor compares each write.
module mc16_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, halted;
    logic [15:0] mem [256];

    typedef struct {
        logic [15:0] addr;
        logic [15:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0, n_err = 0, rd_cnt = 0, pidx = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mc16_core dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic push_wr(input logic [15:0] a, input logic [15:0] d, input string tag);
        exp_t e;
        e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: pops one expected store per write strobe, counts reads.
    always @(negedge clk) begin
        if (rst_n && mem_rd) rd_cnt++;
        if (rst_n && mem_wr) begin
            chk(!mem_rd, "R13", "read strobe during write", 16'(mem_rd), 16'd0);
            if (exp_q.size() == 0)
                chk(1'b0, "R11", "unexpected store", mem_addr, 16'hxxxx);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(mem_addr == e.addr, e.tag, "store address", mem_addr, e.addr);
                chk(mem_wdata == e.data, e.tag, "store data", mem_wdata, e.data);
            end
        end
    end

    function automatic logic [15:0] enc_r(int rs, int rt, int rd, int fn);
        return {3'd0, rs[2:0], rt[2:0], rd[2:0], fn[3:0]};
    endfunction
    function automatic logic [15:0] enc_i(int op, int rs, int rt, int off);
        return {op[2:0], rs[2:0], rt[2:0], off[6:0]};
    endfunction
    function automatic logic [15:0] enc_j(int op, int tgt);
        return {op[2:0], tgt[12:0]};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        pidx = 0;
    endtask
    task automatic emit(input logic [15:0] w);
        mem[pidx] = w;
        pidx++;
    endtask

    // Reset, check start state, release, count cycles until halted.
    task automatic run(output int cyc);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_rd && mem_addr == 16'd0, "R1", "fetch from 0 in reset", mem_addr, 16'd0);
        chk(!halted, "R1", "halted low in reset", 16'(halted), 16'd0);
        rd_cnt = 0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        cyc = 0;
        @(negedge clk);
        chk(!halted && mem_rd && mem_addr == 16'd0, "R1", "first fetch at 0", mem_addr, 16'd0);
        while (!halted && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(halted, "R10", "halt reached", 16'(halted), 16'd1);
    endtask

    task automatic load_prog2();
        clear_mem();
        emit(enc_i(4, 0, 1, 9));   // addi r1 = 9        3 cycles
        emit(enc_i(1, 0, 2, 48));  // lw r2 = mem[0x30]  4 cycles
        emit(enc_i(2, 0, 1, 49));  // sw r1 -> 0x31      3 cycles
        emit(enc_i(3, 0, 0, 0));   // beq taken          4 cycles
        emit(enc_i(3, 1, 0, 0));   // beq not taken      3 cycles
        emit(enc_j(5, 6));         // j 6                3 cycles
        emit(enc_j(7, 0));         // halt
        mem[8'h30] = 16'h5555;
    endtask

    task automatic finish_sim();
        if (done) return;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #1000000;
        chk(1'b0, "R10", "watchdog expired", 16'd0, 16'd1);
        finish_sim();
    end

    initial begin
        int cyc;
        int loop_l;
        logic [15:0] w3;

        // Timing program: cycle totals per instruction class.
        load_prog2();
        push_wr(16'h0031, 16'd9, "R7");
        run(cyc);
        chk(cyc == 22, "R2", "cycles reset-to-halt (3+4+3+4+3+3 then fetch, decode)",
            16'(cyc), 16'd22);
        chk(rd_cnt == 8, "R6", "read strobes (7 fetches + 1 load)", 16'(rd_cnt), 16'd8);
        chk(exp_q.size() == 0, "R7", "pending stores", 16'(exp_q.size()), 16'd0);

        // Halt holds with a quiet bus.
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(halted && !mem_rd && !mem_wr, "R10", "halted and quiet",
                {13'd0, halted, mem_rd, mem_wr}, 16'b100);
        end
        chk(mem[8'h30] == 16'h5555, "R10", "memory untouched in halt", mem[8'h30], 16'h5555);

        // Reset from halt restarts the same program.
        push_wr(16'h0031, 16'd9, "R1");
        run(cyc);
        chk(cyc == 22, "R1", "rerun after reset from halt", 16'(cyc), 16'd22);

        // Function program.
        clear_mem();
        emit(enc_i(4, 0, 1, 5));       // 0  r1 = 5
        emit(enc_i(4, 0, 2, -3));      // 1  r2 = -3
        emit(enc_r(1, 2, 3, 0));       // 2  r3 = add
        emit(enc_r(1, 2, 4, 1));       // 3  r4 = sub
        emit(enc_r(1, 2, 5, 2));       // 4  r5 = and
        emit(enc_r(1, 2, 6, 3));       // 5  r6 = or
        emit(enc_r(2, 1, 7, 4));       // 6  r7 = (-3 < 5)
        emit(enc_i(2, 0, 3, 48));      // 7
        emit(enc_i(2, 0, 4, 49));      // 8
        emit(enc_i(2, 0, 5, 50));      // 9
        emit(enc_i(2, 0, 6, 51));      // 10
        emit(enc_i(2, 0, 7, 52));      // 11
        emit(enc_r(1, 2, 7, 4));       // 12 r7 = (5 < -3)
        emit(enc_i(2, 0, 7, 53));      // 13
        emit(enc_r(1, 2, 3, 9));       // 14 undefined fn
        emit(16'hDFFF);                // 15 undefined opcode 6
        emit(enc_i(2, 0, 3, 54));      // 16
        emit(enc_i(1, 0, 1, 58));      // 17 r1 = mem[0x3A]
        emit(enc_i(2, 0, 1, 55));      // 18
        emit(enc_i(4, 0, 0, 4));       // 19 r0 = 4
        emit(enc_i(1, 0, 2, -1));      // 20 r2 = mem[3]
        emit(enc_i(2, 0, 2, 52));      // 21 -> 0x38
        emit(enc_i(3, 1, 1, 1));       // 22 taken, skip 23
        emit(enc_i(4, 0, 5, 1));       // 23 skipped
        emit(enc_i(2, 0, 5, 53));      // 24 -> 0x39
        emit(enc_i(3, 1, 3, 1));       // 25 not taken
        emit(enc_i(4, 0, 6, 7));       // 26 r6 = 11
        emit(enc_i(2, 0, 6, 54));      // 27 -> 0x3A
        emit(enc_j(5, 30));            // 28 jump over 29
        emit(enc_i(4, 0, 7, 1));       // 29 skipped
        emit(enc_i(2, 0, 7, 55));      // 30 -> 0x3B
        emit(enc_i(4, 0, 3, -1));      // 31 r3 = 3
        loop_l = pidx;
        emit(enc_i(4, 3, 3, -1));      // 32 r3--
        emit(enc_i(4, 4, 4, 1));       // 33 r4++
        emit(enc_i(3, 3, 7, 1));       // 34 exit when r3 == 0
        emit(enc_j(5, loop_l));        // 35 back
        emit(enc_i(2, 0, 4, 56));      // 36 -> 0x3C
        emit(enc_j(7, 0));             // 37 halt
        mem[8'h3A] = 16'h1234;
        w3 = mem[3];

        push_wr(16'h0030, 16'h0002, "R3");
        push_wr(16'h0031, 16'h0008, "R3");
        push_wr(16'h0032, 16'h0005, "R3");
        push_wr(16'h0033, 16'hFFFD, "R5");
        push_wr(16'h0034, 16'h0001, "R4");
        push_wr(16'h0035, 16'h0000, "R4");
        push_wr(16'h0036, 16'h0002, "R11");
        push_wr(16'h0037, 16'h1234, "R6");
        push_wr(16'h0038, w3,       "R12");
        push_wr(16'h0039, 16'h0005, "R8");
        push_wr(16'h003A, 16'd11,   "R8");
        push_wr(16'h003B, 16'h0000, "R9");
        push_wr(16'h003C, 16'd11,   "R8");
        run(cyc);
        chk(exp_q.size() == 0, "R9", "pending stores after program", 16'(exp_q.size()), 16'd0);
        chk(mem[8'h3C] == 16'd11, "R8", "loop count in memory", mem[8'h3C], 16'd11);

        finish_sim();
    end
endmodule